// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit word carried on two rails per bit and produces one `done` signal. It shows whether the whole word has arrived or the whole word has drained back to the spacer state. A bit counts as present as soon as either of its rails is high. The per-bit presence flags are merged by a hysteretic element in the style of a Muller C-element. The output goes high only when every bit is present. It goes low only when every bit has returned to the spacer (both rails low). While the word is partly filled or partly drained, the output keeps its last value. In a handshaking pipeline, this output is what tells the stage upstream that the word has been captured or released.

The state-holding merge is modelled as a register that updates on a clock. The result appears one clock edge after the rail word settles. A separate per-bit error vector and a summary error flag report any bit whose two rails are both high. The block flags such a bit but does not resolve it. The agreement logic ahead of the register can be built as a flat reduction or as a balanced binary tree, chosen by a parameter.

Top module: `dr_completion_detect`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after reset, `done` is 0.
- R2: A bit is present when `rail_t[i]` or `rail_f[i]` is high, so a word completes regardless of which rail each bit uses.
- R3: `done` rises only on the clock edge after a cycle in which every bit was present; the rise is seen on the first edge after the last bit arrives.
- R4: `done` falls only on the clock edge after a cycle in which every bit had both rails low.
- R5: When some bits are present and others are not, `done` holds the value it had before that edge.
- R6: `err_vec[i]` is 1 in the same cycle that `rail_t[i]` and `rail_f[i]` are both high, and 0 otherwise (combinational, no register).
- R7: `err_any` is 1 exactly when at least one bit of `err_vec` is 1.
- R8: A bit with both rails high still counts as present for the merge, so a word with an illegal bit can still raise `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the merge state register |
| rst_n | input | 1 | Asynchronous active-low reset, clears `done` |
| rail_t | input | WIDTH | True rail of each bit |
| rail_f | input | WIDTH | False rail of each bit |
| done | output | 1 | Hysteretic completion flag |
| err_vec | output | WIDTH | Per-bit flag: both rails high |
| err_any | output | 1 | OR of `err_vec` |

## Verification
The bench fills the word one bit at a time in random order, with a random rail per bit. It then drains the word in another random order. After each step it checks that `done` does not move until the final bit. A detector that used a plain AND would drop `done` on the first bit that clears, and the drain phase exposes this. One that used a plain OR would rise on the first bit, and the fill phase exposes that. Directed cases cover two kinds of partial pass: a fill that is abandoned before it completes, which must leave `done` low, and a drain that reverses before it empties, which must leave `done` high. Further cases cover words whose bits use only one rail, and words with both rails high on some bits. A design that ignored the false rail, or dropped illegal bits from the presence test, would never complete those words.

// File: rtl/dr_pkg.sv
package dr_pkg;

   // Variant of the agreement logic in front of the merge register.
   typedef enum logic [0:0] {
      DR_AGREE_FLAT = 1'b0,
      DR_AGREE_TREE = 1'b1
   } dr_agree_style_e;

   // Agreement summary of a group of presence flags.
   typedef struct packed {
      logic all_set;   // every flag in the group is 1
      logic all_clr;   // every flag in the group is 0
   } dr_agree_t;

   function automatic dr_agree_t dr_join(input dr_agree_t a, input dr_agree_t b);
      dr_agree_t r;
      r.all_set = a.all_set & b.all_set;
      r.all_clr = a.all_clr & b.all_clr;
      return r;
   endfunction

endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] rail_t,
   input  logic [WIDTH-1:0] rail_f,
   output logic [WIDTH-1:0] present,
   output logic [WIDTH-1:0] illegal
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dr_rail_decode: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      // R2/R8: either rail, including both, marks the bit present.
      assign present[i] = rail_t[i] | rail_f[i];
      // R6: both rails high is an illegal code.
      assign illegal[i] = rail_t[i] & rail_f[i];
   end

endmodule

// File: rtl/dr_agree_tree.sv
module dr_agree_tree
   import dr_pkg::*;
#(
   parameter int              WIDTH = 8,
   parameter dr_agree_style_e STYLE = DR_AGREE_TREE
) (
   input  logic [WIDTH-1:0] present,
   output dr_agree_t        agree
);

   localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
   localparam int LEAVES = 1 << LEVELS;
   localparam int PAD    = LEAVES - WIDTH;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dr_agree_tree: WIDTH must be at least 1");
      end

      if (STYLE == DR_AGREE_FLAT) begin : g_flat
         assign agree.all_set = &present;
         assign agree.all_clr = ~|present;
      end else begin : g_tree
         logic [LEAVES-1:0] set_leaf;
         logic [LEAVES-1:0] clr_leaf;
         // Padding leaves are neutral for both reductions.
         if (PAD > 0) begin : g_pad
            assign set_leaf = {{PAD{1'b1}}, present};
            assign clr_leaf = {{PAD{1'b1}}, ~present};
         end else begin : g_nopad
            assign set_leaf = present;
            assign clr_leaf = ~present;
         end

         for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
            localparam int NODES = LEAVES >> l;
            dr_agree_t node [NODES];
            for (genvar n = 0; n < NODES; n++) begin : g_node
               if (l == 0) begin : g_leaf
                  assign node[n].all_set = set_leaf[n];
                  assign node[n].all_clr = clr_leaf[n];
               end else begin : g_join
                  assign node[n] = dr_join(g_lvl[l-1].node[2*n], g_lvl[l-1].node[2*n+1]);
               end
            end
         end
         assign agree = g_lvl[LEVELS].node[0];
      end
   endgenerate

endmodule

// File: rtl/dr_celem_state.sv
module dr_celem_state
   import dr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  dr_agree_t agree,
   output logic      done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
      end else if (agree.all_set) begin
         done <= 1'b1;
      end else if (agree.all_clr) begin
         done <= 1'b0;
      end
   end

   // R5: a mixed group leaves the state untouched.
   assert_hold_mixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!agree.all_set && !agree.all_clr) |=> $stable(done));

   // The two agreement flags can never both be set for a non-empty word.
   assert_agree_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(agree.all_set && agree.all_clr));

endmodule

// File: rtl/dr_completion_detect.sv
module dr_completion_detect
   import dr_pkg::*;
#(
   parameter int              WIDTH = 8,
   parameter dr_agree_style_e STYLE = DR_AGREE_TREE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rail_t,
   input  logic [WIDTH-1:0] rail_f,
   output logic             done,
   output logic [WIDTH-1:0] err_vec,
   output logic             err_any
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("dr_completion_detect: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] present;
   dr_agree_t        agree;

   dr_rail_decode #(.WIDTH(WIDTH)) u_decode (
      .rail_t  (rail_t),
      .rail_f  (rail_f),
      .present (present),
      .illegal (err_vec)
   );

   dr_agree_tree #(.WIDTH(WIDTH), .STYLE(STYLE)) u_agree (
      .present (present),
      .agree   (agree)
   );

   dr_celem_state u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .agree (agree),
      .done  (done)
   );

   assign err_any = |err_vec;

   // R1: reset holds the flag low.
   assert_reset_low_R1: assert property (@(posedge clk)
      !rst_n |=> !done);

   // R3: a rise needs a fully present word on the previous edge.
   assert_rise_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(&(rail_t | rail_f)));

   // R4: a fall needs an empty word on the previous edge.
   assert_fall_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(~|(rail_t | rail_f)));

   // R2: a complete word is always followed by done high.
   assert_full_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (&(rail_t | rail_f)) |=> done);

   // R6/R7: error flags track the rail pairs.
   always_comb begin
      if (rst_n) begin
         assert_err_pairs_R6: assert (err_vec == (rail_t & rail_f) || $isunknown(rail_t ^ rail_f));
         assert_err_summary_R7: assert (err_any == (err_vec != '0));
      end
   end

endmodule

// File: tb/dr_completion_detect_tb.sv
module dr_completion_detect_tb;
   import dr_pkg::*;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] rail_t = '0;
   logic [W-1:0] rail_f = '0;
   logic         done;
   logic [W-1:0] err_vec;
   logic         err_any;

   int checks = 0;
   int failures = 0;
   logic exp_done = 1'b0;
   bit finished = 0;

   always #4 clk = ~clk;

   dr_completion_detect #(.WIDTH(W), .STYLE(DR_AGREE_TREE)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .rail_t  (rail_t),
      .rail_f  (rail_f),
      .done    (done),
      .err_vec (err_vec),
      .err_any (err_any)
   );

   function automatic logic model_next(input logic prev, input logic [W-1:0] t, input logic [W-1:0] f);
      logic [W-1:0] p;
      p = t | f;
      if (&p) return 1'b1;
      if (p == '0) return 1'b0;
      return prev;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive a rail word at the falling edge, check errors, then check done one edge later.
   task automatic step(input logic [W-1:0] t, input logic [W-1:0] f, input string req);
      rail_t = t;
      rail_f = f;
      #1;
      check("R6 err_vec", err_vec, t & f);
      check("R7 err_any", {{(W-1){1'b0}}, err_any}, {{(W-1){1'b0}}, |(t & f)});
      exp_done = model_next(exp_done, t, f);
      @(negedge clk);
      check(req, {{(W-1){1'b0}}, done}, {{(W-1){1'b0}}, exp_done});
   endtask

   task automatic shuffle(ref int ord[W]);
      for (int i = 0; i < W; i++) ord[i] = i;
      for (int i = W - 1; i > 0; i--) begin
         int j;
         int tmp;
         j = $urandom_range(i, 0);
         tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
      end
   endtask

   initial begin
      #200000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int ord[W];
      logic [W-1:0] t;
      logic [W-1:0] f;
      logic [W-1:0] pick;
      void'($urandom(32'd20240517));

      @(negedge clk);
      check("R1 done in reset", {{(W-1){1'b0}}, done}, '0);
      rail_t = '1;
      @(negedge clk);
      check("R1 done held in reset with full word", {{(W-1){1'b0}}, done}, '0);
      rail_t = '0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_done = 1'b0;
      @(negedge clk);
      check("R1 done after reset", {{(W-1){1'b0}}, done}, '0);

      // Random fill and drain passes: R3 on the fill, R4 on the drain, R5 between.
      for (int trial = 0; trial < 40; trial++) begin
         pick = W'($urandom);
         t = '0; f = '0;
         shuffle(ord);
         for (int k = 0; k < W; k++) begin
            if (pick[ord[k]]) t[ord[k]] = 1'b1; else f[ord[k]] = 1'b1;
            step(t, f, (k == W - 1) ? "R3 done rises on last bit" : "R5 done held during fill");
         end
         shuffle(ord);
         for (int k = 0; k < W; k++) begin
            t[ord[k]] = 1'b0; f[ord[k]] = 1'b0;
            step(t, f, (k == W - 1) ? "R4 done falls on last clear" : "R5 done held during drain");
         end
      end

      // R2: only true rails, then only false rails.
      step('1, '0, "R2 all true rails complete");
      step('0, '0, "R4 empty after true word");
      step('0, '1, "R2 all false rails complete");
      step('0, '0, "R4 empty after false word");

      // R5: abandoned fill leaves done low.
      step(8'h0F, 8'h00, "R5 partial fill stays low");
      step(8'h0F, 8'h70, "R5 partial fill stays low");
      step(8'h00, 8'h00, "R5 back to empty stays low");

      // R5: reversed drain leaves done high.
      step(8'hAA, 8'h55, "R3 full word raises");
      step(8'h0A, 8'h05, "R5 partial drain stays high");
      step(8'hAA, 8'h55, "R5 refilled stays high");
      step(8'h00, 8'h00, "R4 empty drops");

      // R8 with R6/R7: illegal bits still count as present.
      step(8'h81, 8'h81, "R8 illegal bits partial");
      step(8'hFF, 8'h81, "R8 word with illegal bits completes");
      step(8'h00, 8'h00, "R4 empty after illegal word");
      step(8'h10, 8'h10, "R6 single illegal bit");
      step(8'h00, 8'h00, "R4 empty again");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule